// File: doc/BRIEF.md
# Per-Port Interrupt Latch Bank

This block collects event pulses from the ports of a twelve-port repeater, which also has an attachment unit port, a reverse attachment unit port and an expansion port. It holds them in three 16-bit interrupt status registers. One register records partition-state changes, one records runt frames that carried a correct FCS, and one records link-test changes on the twisted-pair ports. Each status register has a matching enable register. A status bit can only become set while its enable bit is set.

A host reaches the registers one byte at a time through a small address space. Writing a bank code to the command address chooses which group appears at the register addresses. One code shows the status registers, which clear when read. Another code shows the enable registers, which can be read and written. The command address also reads back a one-bit interrupt summary in any bank.

A single registered, active-high interrupt line is high while any status bit is set. It drops only when all three status registers are zero. Event detection happens outside the block. Events arrive as one-cycle pulses on per-port inputs, and every cycle an input is high counts as an event.

Top module: `irqb_top`

## Requirements
- R1: Address 0 is the command address. Writing 8'h01 there selects the status bank, and writing 8'h02 selects the enable bank. With any other code, reads of addresses 1 to 6 return 8'h00 and clear nothing, and writes to them are ignored.
- R2: In the enable bank, addresses 1 to 6 are read/write enable bytes, laid out as in R4 to R6. Bits that have no port always read 0 (address 2 reads at most 8'h3F, address 4 at most 8'h7F, address 6 at most 8'h0F).
- R3: A status bit becomes set only when its event input is high in a cycle where the matching enable bit is already set.
- R4: Partition register. Address 1 holds ports 7 to 0, with bit n = port n. Address 2 holds ports 11 to 8 in bits 3:0, the attachment unit port in bit 4 and the reverse attachment unit port in bit 5.
- R5: Runt register. Addresses 3 and 4 use the layout of R4. In addition, bit 6 of address 4 holds the expansion port.
- R6: Link register. Address 5 holds twisted-pair ports 7 to 0, and address 6 holds ports 11 to 8 in bits 3:0.
- R7: A read strobe in the status bank returns the addressed byte on rdata_o one cycle later, showing its value before the clear. It clears that byte and no other byte.
- R8: An event that arrives in the same cycle as a clearing read of its byte leaves its bit set.
- R9: irq_o rises one clock after any status bit becomes set. It stays high while any status bit is set.
- R10: irq_o falls one clock after all status registers have become zero.
- R11: A read of address 0 in any bank returns {7'b0, irq_o} and has no side effect.
- R12: Reset clears all status bits, all enable bits, the bank code, irq_o and rdata_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_i | input | 1 | Byte write strobe |
| rd_i | input | 1 | Byte read strobe |
| addr_i | input | 3 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| part_evt_i | input | 14 | Partition-change pulses: ports 0-11, attachment unit port (12), reverse attachment unit port (13) |
| runt_evt_i | input | 15 | Good-FCS runt pulses: as part_evt_i plus expansion port (14) |
| link_evt_i | input | 12 | Link-test change pulses for twisted-pair ports 0-11 |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The bench drives an event on the same cycle as the clearing read of that byte. A design that lets the clear win would lose the event, and the follow-up read would show zero. It clears one byte of a register while the other byte is still set, which catches a design that wipes the whole word on one read. It keeps a second register pending after the first one has been cleared, which exposes an interrupt line that drops too early. It reads and writes under an unused bank code, which catches address decoding that ignores the bank and so clears status or overwrites enables. The bench also samples irq_o in the cycle before it should rise, so an unregistered or doubly registered line is reported.

// File: rtl/irqb_pkg.sv
package irqb_pkg;

    localparam int PORTS   = 12;
    localparam int REG_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int NBYTE   = REG_W / BYTE_W;
    localparam int NREG    = 3;
    localparam int ADDR_W  = 3;
    localparam int SRC_W   = $clog2(NREG);

    localparam int PART_W  = PORTS + 2;
    localparam int RUNT_W  = PORTS + 3;
    localparam int LINK_W  = PORTS;

    localparam logic [BYTE_W-1:0] BANK_STAT = 8'h01;
    localparam logic [BYTE_W-1:0] BANK_ENA  = 8'h02;
    localparam logic [ADDR_W-1:0] ADDR_CMD  = '0;

    typedef enum logic [SRC_W-1:0] {
        SRC_PART = 2'd0,
        SRC_RUNT = 2'd1,
        SRC_LINK = 2'd2
    } src_e;

    typedef struct packed {
        logic             cmd_rd;
        logic             reg_hit;
        logic             in_stat;
        logic             in_ena;
        logic [SRC_W-1:0] src;
        logic             hi;
    } acc_t;

    typedef logic [NREG-1:0][REG_W-1:0]  regvec_t;
    typedef logic [NREG-1:0][NBYTE-1:0]  bytestb_t;

    function automatic int src_width(input int s);
        case (s)
            0:       return PART_W;
            1:       return RUNT_W;
            default: return LINK_W;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] valid_mask(input int s);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < REG_W; i++) begin
            if (i < src_width(s)) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [REG_W-1:0] v,
                                                    input logic hi);
        return hi ? v[REG_W-1:BYTE_W] : v[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/irqb_decode.sv
module irqb_decode
    import irqb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output acc_t              acc_o,
    output bytestb_t          clr_o,
    output bytestb_t          ena_wr_o
);

    logic [BYTE_W-1:0] bank_q;
    logic [ADDR_W-1:0] off;
    logic              hit;
    logic [SRC_W-1:0]  src;
    logic              hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else if (wr_i && addr_i == ADDR_CMD) begin
            bank_q <= wdata_i;
        end
    end

    always_comb begin
        off = addr_i - ADDR_W'(1);
        hit = (addr_i != ADDR_CMD) && (off < ADDR_W'(NREG * NBYTE));
        src = off[SRC_W:1];
        hi  = off[0];
    end

    always_comb begin
        acc_o.cmd_rd  = rd_i && (addr_i == ADDR_CMD);
        acc_o.reg_hit = hit;
        acc_o.in_stat = (bank_q == BANK_STAT);
        acc_o.in_ena  = (bank_q == BANK_ENA);
        acc_o.src     = src;
        acc_o.hi      = hi;
    end

    for (genvar s = 0; s < NREG; s++) begin : g_src
        for (genvar b = 0; b < NBYTE; b++) begin : g_byte
            always_comb begin
                clr_o[s][b]    = rd_i && hit && acc_o.in_stat
                                 && (src == SRC_W'(s)) && (hi == 1'(b));
                ena_wr_o[s][b] = wr_i && hit && acc_o.in_ena
                                 && (src == SRC_W'(s)) && (hi == 1'(b));
            end
        end
    end

    a_r1_one_clear: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_o));

    a_r1_bank_exclusive: assert property (@(posedge clk) disable iff (rst)
        !((|clr_o) && (|ena_wr_o)));

endmodule

// File: rtl/irqb_latch_reg.sv
module irqb_latch_reg
    import irqb_pkg::*;
#(
    parameter logic [REG_W-1:0] VALID = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_W-1:0]  evt_i,
    input  logic [NBYTE-1:0]  clr_i,
    input  logic [NBYTE-1:0]  ena_wr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [REG_W-1:0]  stat_o,
    output logic [REG_W-1:0]  ena_o
);

    logic [REG_W-1:0] stat_q;
    logic [REG_W-1:0] ena_q;
    logic [REG_W-1:0] set_v;
    logic [REG_W-1:0] clr_v;

    assign set_v = evt_i & ena_q & VALID;

    for (genvar b = 0; b < NBYTE; b++) begin : g_byte
        assign clr_v[b*BYTE_W +: BYTE_W] = {BYTE_W{clr_i[b]}};

        always_ff @(posedge clk) begin
            if (rst) begin
                ena_q[b*BYTE_W +: BYTE_W] <= '0;
            end else if (ena_wr_i[b]) begin
                ena_q[b*BYTE_W +: BYTE_W] <= wdata_i & VALID[b*BYTE_W +: BYTE_W];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                stat_q[b*BYTE_W +: BYTE_W] <= '0;
            end else begin
                stat_q[b*BYTE_W +: BYTE_W] <=
                    (stat_q[b*BYTE_W +: BYTE_W] & ~clr_v[b*BYTE_W +: BYTE_W])
                    | set_v[b*BYTE_W +: BYTE_W];
            end
        end
    end

    assign stat_o = stat_q;
    assign ena_o  = ena_q;

    a_r3_set_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (stat_q & ~$past(stat_q) & ~$past(ena_q)) == '0);

    a_r8_event_beats_clear: assert property (@(posedge clk) disable iff (rst)
        ($past(evt_i & ena_q & VALID) & ~stat_q) == '0);

    a_r7_read_clears_byte: assert property (@(posedge clk) disable iff (rst)
        (stat_q & $past(clr_v) & ~$past(evt_i & ena_q)) == '0);

    a_r2_no_phantom_bits: assert property (@(posedge clk) disable iff (rst)
        ((stat_q | ena_q) & ~VALID) == '0);

endmodule

// File: rtl/irqb_summary.sv
module irqb_summary
    import irqb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  regvec_t stat_i,
    output logic    irq_o
);

    logic any_set;
    logic irq_q;

    always_comb begin
        any_set = 1'b0;
        for (int s = 0; s < NREG; s++) begin
            any_set = any_set | (|stat_i[s]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= any_set;
    end

    assign irq_o = irq_q;

    a_r9_irq_follows_pending: assert property (@(posedge clk) disable iff (rst)
        (stat_i != '0) |=> irq_q);

    a_r10_irq_drops_when_clear: assert property (@(posedge clk) disable iff (rst)
        (stat_i == '0) |=> !irq_q);

endmodule

// File: rtl/irqb_top.sv
module irqb_top
    import irqb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] rdata_o,
    input  logic [PART_W-1:0] part_evt_i,
    input  logic [RUNT_W-1:0] runt_evt_i,
    input  logic [LINK_W-1:0] link_evt_i,
    output logic              irq_o
);

    acc_t     acc;
    bytestb_t clr;
    bytestb_t ena_wr;
    regvec_t  evt_v;
    regvec_t  stat_v;
    regvec_t  ena_v;
    logic [BYTE_W-1:0] rd_byte;
    logic [BYTE_W-1:0] rdata_q;
    logic              irq;

    always_comb begin
        evt_v = '0;
        evt_v[SRC_PART][PART_W-1:0] = part_evt_i;
        evt_v[SRC_RUNT][RUNT_W-1:0] = runt_evt_i;
        evt_v[SRC_LINK][LINK_W-1:0] = link_evt_i;
    end

    irqb_decode u_decode (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (wr_i),
        .rd_i     (rd_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .acc_o    (acc),
        .clr_o    (clr),
        .ena_wr_o (ena_wr)
    );

    for (genvar s = 0; s < NREG; s++) begin : g_reg
        irqb_latch_reg #(
            .VALID (valid_mask(s))
        ) u_latch (
            .clk      (clk),
            .rst      (rst),
            .evt_i    (evt_v[s]),
            .clr_i    (clr[s]),
            .ena_wr_i (ena_wr[s]),
            .wdata_i  (wdata_i),
            .stat_o   (stat_v[s]),
            .ena_o    (ena_v[s])
        );
    end

    irqb_summary u_summary (
        .clk    (clk),
        .rst    (rst),
        .stat_i (stat_v),
        .irq_o  (irq)
    );

    always_comb begin
        rd_byte = '0;
        if (acc.cmd_rd) begin
            rd_byte = {{(BYTE_W-1){1'b0}}, irq};
        end else if (acc.reg_hit) begin
            for (int s = 0; s < NREG; s++) begin
                if (acc.src == SRC_W'(s)) begin
                    if (acc.in_stat)     rd_byte = pick_byte(stat_v[s], acc.hi);
                    else if (acc.in_ena) rd_byte = pick_byte(ena_v[s], acc.hi);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       rdata_q <= '0;
        else if (rd_i) rdata_q <= rd_byte;
    end

    assign rdata_o = rdata_q;
    assign irq_o   = irq;

    a_r11_cmd_read_reports_irq: assert property (@(posedge clk) disable iff (rst)
        (rd_i && addr_i == ADDR_CMD) |=> (rdata_o == {{(BYTE_W-1){1'b0}}, $past(irq)}));

endmodule

// File: tb/irqb_top_tb.sv
`timescale 1ns/1ps
module irqb_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [2:0]  addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic [7:0]  rdata_o;
    logic [13:0] part_evt_i = '0;
    logic [14:0] runt_evt_i = '0;
    logic [11:0] link_evt_i = '0;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    logic pend = 1'b0;
    logic done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    irqb_top u_dut (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (wr_i),
        .rd_i       (rd_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .rdata_o    (rdata_o),
        .part_evt_i (part_evt_i),
        .runt_evt_i (runt_evt_i),
        .link_evt_i (link_evt_i),
        .irq_o      (irq_o)
    );

    // Monitor: a read strobe seen at an edge yields data at the next falling edge.
    always @(posedge clk) pend <= rd_i;

    always @(negedge clk) begin
        if (pend) begin
            item_t it;
            checks++;
            if (sb.size() == 0) begin
                failures++;
                $display("FAIL scoreboard empty: actual=%h expected=none", rdata_o);
            end else begin
                it = sb.pop_front();
                if (rdata_o !== it.exp) begin
                    failures++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, rdata_o, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic rd_ev(input logic [2:0] a, input logic [7:0] e, input string tag,
                         input logic [13:0] p, input logic [14:0] r, input logic [11:0] l);
        item_t it;
        @(negedge clk);
        rd_i = 1'b1; addr_i = a;
        part_evt_i = p; runt_evt_i = r; link_evt_i = l;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        rd_i = 1'b0;
        part_evt_i = '0; runt_evt_i = '0; link_evt_i = '0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        rd_ev(a, e, tag, '0, '0, '0);
    endtask

    task automatic pulse(input logic [13:0] p, input logic [14:0] r, input logic [11:0] l);
        @(negedge clk);
        part_evt_i = p; runt_evt_i = r; link_evt_i = l;
        @(negedge clk);
        part_evt_i = '0; runt_evt_i = '0; link_evt_i = '0;
    endtask

    // Checks irq_o at the current falling edge (no wait).
    task automatic irq_now(input logic e, input string tag);
        checks++;
        if (irq_o !== e) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b", tag, irq_o, e);
        end
    endtask

    task automatic irq_next(input logic e, input string tag);
        @(negedge clk);
        irq_now(e, tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12: reset state
        irq_now(1'b0, "R12 irq after reset");
        rd(3'd0, 8'h00, "R12 status after reset");
        wr(3'd0, 8'h02);
        rd(3'd1, 8'h00, "R12 enable after reset");

        // R3: event with enable clear is not latched
        pulse(14'h0004, '0, '0);
        wr(3'd0, 8'h01);
        rd(3'd1, 8'h00, "R3 no latch without enable");
        irq_next(1'b0, "R3 irq stays low");

        // R2: enable bank read/write with masked unused bits
        wr(3'd0, 8'h02);
        for (int a = 1; a <= 6; a++) wr(3'(a), 8'hFF);
        rd(3'd1, 8'hFF, "R2 enable part lo");
        rd(3'd2, 8'h3F, "R2 enable part hi");
        rd(3'd3, 8'hFF, "R2 enable runt lo");
        rd(3'd4, 8'h7F, "R2 enable runt hi");
        rd(3'd5, 8'hFF, "R2 enable link lo");
        rd(3'd6, 8'h0F, "R2 enable link hi");

        // R4, R9, R10, R11: partition bits, irq timing
        wr(3'd0, 8'h01);
        pulse(14'h2008, '0, '0);
        irq_now(1'b0, "R9 irq one clock late");
        irq_next(1'b1, "R9 irq rises");
        rd(3'd0, 8'h01, "R11 status shows irq");
        rd(3'd1, 8'h08, "R4 port 3 in lo byte");
        irq_now(1'b1, "R9 irq held while hi byte set");
        rd(3'd2, 8'h20, "R4 reverse port bit 5");
        irq_now(1'b1, "R10 irq one clock after clear");
        irq_next(1'b0, "R10 irq falls");
        rd(3'd0, 8'h00, "R11 status shows no irq");

        // R5: runt with expansion port
        pulse('0, 15'h4001, '0);
        rd(3'd3, 8'h01, "R5 runt port 0");
        rd(3'd4, 8'h40, "R5 expansion bit 6");
        pulse('0, 15'h1000, '0);
        rd(3'd4, 8'h10, "R5 attachment port bit 4");

        // R6: link register
        pulse('0, '0, 12'h200);
        rd(3'd6, 8'h02, "R6 port 9");
        rd(3'd5, 8'h00, "R6 lo byte empty");

        // R7: clearing touches only the read byte
        pulse(14'h0202, '0, '0);
        rd(3'd1, 8'h02, "R7 lo byte value");
        rd(3'd1, 8'h00, "R7 lo byte cleared");
        rd(3'd2, 8'h02, "R7 hi byte survives");
        rd(3'd2, 8'h00, "R7 hi byte cleared");

        // R8: event in the same cycle as the clearing read
        pulse(14'h0020, '0, '0);
        rd_ev(3'd1, 8'h20, "R8 read returns pre-clear", 14'h0040, '0, '0);
        rd(3'd1, 8'h40, "R8 coincident event kept");
        rd(3'd1, 8'h00, "R8 cleared afterwards");

        // R9: irq stays while another register is pending
        pulse(14'h0001, '0, 12'h001);
        rd(3'd1, 8'h01, "R9 partition read");
        irq_next(1'b1, "R9 irq held by link register");
        rd(3'd5, 8'h01, "R9 link read");
        irq_next(1'b0, "R10 irq falls after last clear");

        // R1: unused bank code neither reads, clears nor writes
        pulse(14'h0001, '0, '0);
        wr(3'd0, 8'h03);
        rd(3'd1, 8'h00, "R1 unused bank reads zero");
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h01);
        rd(3'd1, 8'h01, "R1 status not cleared");
        wr(3'd0, 8'h02);
        rd(3'd1, 8'hFF, "R1 enable not overwritten");
        irq_now(1'b0, "R1 irq low after clear");

        // R3: partial enable
        wr(3'd1, 8'h01);
        pulse(14'h0003, '0, '0);
        wr(3'd0, 8'h01);
        rd(3'd1, 8'h01, "R3 only enabled bit set");
        irq_next(1'b0, "R3 irq low at end");

        repeat (2) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL scoreboard leftover: actual=%0d expected=0", sb.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule